// File: doc/BRIEF.md
# Infrared SIR Line Encoder and Decoder

This block sits between a UART and an infrared transceiver. It converts the UART's NRZ serial stream into return-to-zero infrared signalling of the SIR kind, and converts the pulses it receives back into NRZ. All timing comes from a 16x bit-rate clock enable (`tick16`), so one bit cell lasts 16 enable ticks. On the transmit side, a zero bit becomes a short high pulse at the start of its cell, and a one bit sends nothing, so the line idles low. On the receive side, each pulse is synchronised, and its rising edge opens a low period that lasts about one bit cell. A pulse that arrives during that period restarts it, so a run of zero bits comes out as one continuous low level. With no pulses the output rests high, which is what a UART receiver expects.

An enable input `ir_en` chooses the mode. When it is low, both directions pass straight through with no register, and the line has the normal high idle. The serial signals are timed levels, not transfers, so there is no valid/ready handshake and no back-pressure. The UART may change `tx_nrz` only on bit-cell boundaries, and the receive side accepts pulses at any time.

Top module: `irsir_codec`

## Requirements
- R1: When `ir_en` is 0, `tx_ir` equals `tx_nrz` and `rx_nrz` equals `rx_ir` in the same cycle, with no register in the path.
- R2: After reset with `ir_en` at 1, `tx_ir` is 0 and `rx_nrz` is 1 until stimulus arrives.
- R3: The encoder samples `tx_nrz` on each tick. For a 0 bit, `tx_ir` is 1 during cell counts 0, 1 and 2: it rises after the tick edge that starts the cell and lasts exactly 3 tick periods (12 clocks with a tick every 4 clocks).
- R4: A cell carrying a 1 bit leaves `tx_ir` at 0 for the whole cell.
- R5: The cell count restarts at 0 on any tick where `tx_nrz` differs from the previously sampled bit. Otherwise it wraps modulo 16. As a result, each of several consecutive 0 bits gets its own pulse.
- R6: `rx_ir` passes through a two-flop synchroniser. A rising edge drives `rx_nrz` to 0 at the third clock edge after `rx_ir` rises. With no further edge, `rx_nrz` returns to 1 on the 17th tick after that. An isolated pulse therefore gives a low period of 65 to 68 clocks at 4 clocks per tick.
- R7: A new rising edge while `rx_nrz` is low reloads the 17-tick hold, so back-to-back zero bits give a continuous low level with no high glitch.
- R8: When `tx_ir` is looped back to `rx_ir`, the value of `rx_nrz` at the middle of each cell matches the bit sent in that cell, for whole UART frames.
- R9: Clearing `ir_en` abandons any hold in progress, so `rx_nrz` is 1 as soon as infrared mode is enabled again with `rx_ir` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| ir_en | input | 1 | 1 selects infrared mode, 0 selects pass-through |
| tx_nrz | input | 1 | NRZ serial data from the UART transmitter |
| tx_ir | output | 1 | Line to the infrared emitter |
| rx_ir | input | 1 | Line from the infrared detector |
| rx_nrz | output | 1 | NRZ serial data to the UART receiver |

## Verification
The hardest case to reach is the seam between two zero bits on the receive side. There, the 17-tick hold of one pulse must overlap the synchroniser delay of the next pulse with no high glitch in between. The bench reaches it by looping the encoder output into the decoder and sending frames with runs of zeros. In each cell it counts how many cycles `rx_nrz` is low and compares that count with the exact figure derived from the 3-edge latency and the 17-tick hold. A separate directed test places two raw pulses 40 clocks apart and checks the length of the merged low period.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  typedef enum logic {
    LINK_NRZ = 1'b0,
    LINK_SIR = 1'b1
  } link_mode_e;
endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irsir_encoder.sv
module irsir_encoder #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic nrz_in,
  output logic pulse_out
);
  localparam int PH_W = $clog2(OVERSAMPLE);

  logic [PH_W-1:0] phase_q, phase_nxt;
  logic            bit_q;
  logic            pulse_q;
  logic            bit_change;

  // Cell counter realigns on every data transition, else wraps per cell.
  always_comb begin
    bit_change = (nrz_in != bit_q);
    if (bit_change)                              phase_nxt = '0;
    else if (phase_q == PH_W'(OVERSAMPLE - 1))   phase_nxt = '0;
    else                                         phase_nxt = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b1;
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else if (tick) begin
      bit_q   <= nrz_in;
      phase_q <= phase_nxt;
      pulse_q <= enable && !nrz_in && (phase_nxt < PH_W'(PULSE_TICKS));
    end else if (!enable) begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_out = pulse_q;
endmodule

// File: rtl/irsir_decoder.sv
module irsir_decoder #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic ir_sync,
  output logic nrz_out
);
  // One extra tick covers synchroniser latency so adjacent zero cells merge.
  localparam int LOAD  = HOLD_TICKS + 1;
  localparam int CNT_W = $clog2(LOAD + 1);

  logic             prev_q;
  logic [CNT_W-1:0] hold_q;
  logic             rise;

  assign rise = ir_sync && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= ir_sync;
      if (!enable)                  hold_q <= '0;
      else if (rise)                hold_q <= CNT_W'(LOAD);
      else if (tick && hold_q != '0) hold_q <= hold_q - CNT_W'(1);
    end
  end

  assign nrz_out = (hold_q == '0);
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3,
  parameter int HOLD_TICKS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_en,
  input  logic tx_nrz,
  output logic tx_ir,
  input  logic rx_ir,
  output logic rx_nrz
);
  link_mode_e mode;
  logic       enc_pulse;
  logic       rx_synced;
  logic       dec_nrz;

  assign mode = ir_en ? LINK_SIR : LINK_NRZ;

  irsir_encoder #(
    .OVERSAMPLE (OVERSAMPLE),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .enable   (ir_en),
    .nrz_in   (tx_nrz),
    .pulse_out(enc_pulse)
  );

  irsir_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b0)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rx_ir),
    .q    (rx_synced)
  );

  irsir_decoder #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .enable (ir_en),
    .ir_sync(rx_synced),
    .nrz_out(dec_nrz)
  );

  always_comb begin
    case (mode)
      LINK_SIR: begin
        tx_ir  = enc_pulse;
        rx_nrz = dec_nrz;
      end
      default: begin
        tx_ir  = tx_nrz;
        rx_nrz = rx_ir;
      end
    endcase
  end
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk #(
  parameter int PULSE_TICKS = 3,
  parameter int HOLD_TICKS  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic ir_en,
  input logic tx_nrz,
  input logic tx_ir,
  input logic rx_ir,
  input logic rx_nrz
);
  logic [15:0] hi_ticks;
  logic [15:0] lo_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_ticks <= '0;
    else if (!ir_en || !tx_ir) hi_ticks <= '0;
    else if (tick16)           hi_ticks <= hi_ticks + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lo_ticks <= '0;
    else if (!ir_en || rx_nrz || rx_ir)  lo_ticks <= '0;
    else if (tick16)                     lo_ticks <= lo_ticks + 16'd1;
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en |-> (tx_ir == tx_nrz) && (rx_nrz == rx_ir));

  assert_idle_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && !$past(rst_n)) |-> (!tx_ir && rx_nrz));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= 16'(PULSE_TICKS));

  assert_no_pulse_for_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && $rose(tx_ir)) |-> !$past(tx_nrz));

  assert_hold_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ticks <= 16'(HOLD_TICKS + 1));
endmodule

bind irsir_codec irsir_codec_chk #(
  .PULSE_TICKS(PULSE_TICKS),
  .HOLD_TICKS (HOLD_TICKS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick16(tick16),
  .ir_en (ir_en),
  .tx_nrz(tx_nrz),
  .tx_ir (tx_ir),
  .rx_ir (rx_ir),
  .rx_nrz(rx_nrz)
);

// File: tb/irsir_codec_bench.sv
module irsir_codec_bench;
  localparam int TDIV   = 4;
  localparam int OVS    = 16;
  localparam int PULSE  = 3;
  localparam int HOLD   = 16;
  localparam int CELL   = TDIV * OVS;
  localparam int LAT    = 3;
  localparam int REL    = TDIV * (HOLD + 1) + 1 - CELL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic ir_en = 1'b1;
  logic tx_nrz = 1'b1;
  logic rx_ir = 1'b0;
  logic tx_ir, rx_nrz;

  int  checks = 0, failures = 0, tcnt = 0;
  bit  loop = 1'b0, done = 1'b0, prev_zero = 1'b0;
  logic s_tx, s_rx;

  always #4 clk = ~clk;

  irsir_codec u_irsir_codec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_en(ir_en),
    .tx_nrz(tx_nrz), .tx_ir(tx_ir), .rx_ir(rx_ir), .rx_nrz(rx_nrz)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    s_tx = tx_ir;
    s_rx = rx_nrz;
    if (loop) rx_ir = tx_ir;
    tick16 = (tcnt == TDIV - 1);
    tcnt = (tcnt + 1) % TDIV;
  endtask

  task automatic align();
    while (tcnt != TDIV - 1) step();
  endtask

  // One bit cell; tx_nrz set just before the tick edge that starts it.
  task automatic send_cell(input bit b, input string tag);
    int hi = 0, lo = 0, exp_hi, exp_lo;
    bit first = 1'b0, mid = 1'b0;
    tx_nrz = b;
    for (int i = 0; i < CELL; i++) begin
      step();
      if (s_tx) hi++;
      if (!s_rx) lo++;
      if (i == 1) first = s_tx;
      if (i == CELL / 2) mid = s_rx;
    end
    exp_hi = b ? 0 : PULSE * TDIV;
    check(hi == exp_hi, {tag, " pulse width"}, hi, exp_hi);
    if (!b) check(first == 1'b1, {tag, " pulse at cell start"}, first, 1);
    if (loop) begin
      check(mid == b, "R8 mid-cell recovered bit", mid, b);
      if (b) exp_lo = prev_zero ? REL : 0;
      else   exp_lo = prev_zero ? CELL : CELL - (LAT + 1);
      check(lo == exp_lo, b ? "R6 release timing" : (prev_zero ? "R7 merged zeros" : "R6 fall timing"),
            lo, exp_lo);
    end
    prev_zero = !b;
  endtask

  task automatic send_frame(input logic [7:0] data);
    send_cell(1'b0, "R3");
    for (int k = 0; k < 8; k++)
      send_cell(data[k], data[k] ? "R4" : (k > 0 && !data[k-1]) ? "R5" : "R3");
    send_cell(1'b1, "R4");
  endtask

  task automatic measure_low(input int gap, output int lo);
    lo = 0;
    rx_ir = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rx_ir = 1'b0;
    if (gap > 0) begin
      for (int i = 3; i < gap; i++) begin step(); if (!s_rx) lo++; end
      rx_ir = 1'b1;
      for (int i = 0; i < 3; i++) begin step(); if (!s_rx) lo++; end
      rx_ir = 1'b0;
      for (int i = 0; i < 150; i++) begin step(); if (!s_rx) lo++; end
      lo = lo + 0;
    end else begin
      for (int i = 0; i < 150; i++) begin step(); if (!s_rx) lo++; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 5; i++) step();
    rst_n = 1'b1;
    step();
    check(tx_ir == 1'b0, "R2 tx idle low", tx_ir, 0);
    check(rx_nrz == 1'b1, "R2 rx idle high", rx_nrz, 1);
    for (int i = 0; i < 40; i++) step();
    check(tx_ir == 1'b0 && rx_nrz == 1'b1, "R2 idle holds", {tx_ir, rx_nrz}, 1);
  endtask

  task automatic t_passthru();
    ir_en = 1'b0;
    for (int p = 0; p < 4; p++) begin
      step();
      tx_nrz = p[0];
      rx_ir  = p[1];
      #1;
      check(tx_ir == tx_nrz, "R1 tx pass-through", tx_ir, tx_nrz);
      check(rx_nrz == rx_ir, "R1 rx pass-through", rx_nrz, rx_ir);
    end
    tx_nrz = 1'b1;
    rx_ir  = 1'b0;
    ir_en  = 1'b1;
    for (int i = 0; i < CELL; i++) step();
  endtask

  task automatic t_encode();
    loop = 1'b0;
    align();
    send_frame(8'h4C);
  endtask

  task automatic t_loopback();
    loop = 1'b1;
    align();
    prev_zero = 1'b0;
    send_cell(1'b1, "R4");
    send_frame(8'hB3);
    send_frame(8'h00);
    send_cell(1'b1, "R4");
    loop = 1'b0;
    rx_ir = 1'b0;
  endtask

  task automatic t_hold();
    int lo;
    for (int i = 0; i < 100; i++) step();
    measure_low(0, lo);
    check(lo >= TDIV * HOLD + 1 && lo <= TDIV * (HOLD + 1), "R6 isolated hold length", lo, TDIV * HOLD + 1);
    measure_low(40, lo);
    check(lo >= 40 + TDIV * HOLD + 1 && lo <= 40 + TDIV * (HOLD + 1), "R7 retriggered hold length",
          lo, 40 + TDIV * HOLD + 1);
  endtask

  task automatic t_mode_clear();
    rx_ir = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rx_ir = 1'b0;
    for (int i = 0; i < 10; i++) step();
    check(rx_nrz == 1'b0, "R9 hold active before disable", rx_nrz, 0);
    ir_en = 1'b0;
    for (int i = 0; i < 3; i++) step();
    ir_en = 1'b1;
    step();
    check(rx_nrz == 1'b1, "R9 hold cleared on re-enable", rx_nrz, 1);
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_encode();
    t_loopback();
    t_hold();
    t_mode_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule